// File: doc/BRIEF.md
# Two-Wire Byte-Write Master with Side-Effect Status Flags

This block is the write-only master side of a two-wire (I2C) bus. A host or a DMA engine programs a 7-bit slave address and a clock divider, then pushes data bytes one at a time into a one-byte holding register. A holding-register write made while the bus is free opens a transfer: a START, the address byte with the write bit, then each data byte in turn. Every ninth clock carries the slave's acknowledge. The block drives both lines through open-drain style "pull low" outputs and reads the data line back.

A three-bit status word reports transmit-ready (holding register empty), transmit-complete and not-acknowledged. Register accesses clear these flags as a side effect. Reading status clears not-acknowledged, and writing the holding register clears transmit-complete. On a missing acknowledge the master sends a STOP by itself and drops any byte still held. All three flags go up in the same clock, so a DMA engine reacting to transmit-ready can open a new transfer that nobody intended. An interrupt line is the OR of the flags under an enable mask. A DMA request pulses once each time transmit-ready rises.

The byte path has no back-pressure at the register port. The transmit-ready flag and the DMA request act as the "ready" side. A writer that loads the holding register while it is still full overwrites the pending byte.

Top module: `i2c_txm_top`

## Requirements
- R1: After reset the status word reads transmit-ready=1 (bit 0), transmit-complete=1 (bit 1) and not-acknowledged=0 (bit 2). The enable mask reads 0, both line outputs are released (0) and irq is 0.
- R2: A write to the holding register (address 2) while the bus is free produces a START (SDA falls while SCL is high). The address byte {slave address, 0} follows, then the data bytes in the order they were written, MSB first. The master samples the acknowledge at the end of the ninth SCL high phase.
- R3: Transmit-ready is 0 while the holding register holds a byte and 1 once that byte moves to the shifter. dma_req is a single-cycle pulse on each rise of transmit-ready.
- R4: After an acknowledged byte, if no new byte is waiting and no stop is pending, the master sets transmit-complete and holds SCL low without a STOP. A later holding-register write continues the same transfer with that byte.
- R5: A write to the holding register clears transmit-complete from the next cycle.
- R6: Writing 1 to bit 0 of address 0 while a transfer is open or pending ends the transfer with a STOP after the current byte, with no further bytes waiting. The same write while the bus is free has no effect.
- R7: A missing acknowledge makes the master send a STOP without any host command and discard the held byte. No new START follows unless a byte is written afterwards.
- R8: In the cycle that not-acknowledged becomes 1, transmit-complete and transmit-ready are also 1.
- R9: A status read strobe (reg_rd at address 3) clears not-acknowledged. Looking at reg_rdata with reg_rd low leaves the flag alone.
- R10: irq is the OR of the status bits under the enable mask. Address 4 sets mask bits and address 5 clears them; address 6 reads the mask. Enabling a flag that is already set raises irq in the next cycle.
- R11: Each SCL high and low phase of a data bit lasts (divider + 1) clock cycles, where the divider is written at address 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only side effects depend on it) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Level sensed on the SDA line |
| irq | output | 1 | Masked status interrupt |
| dma_req | output | 1 | One-cycle request on each rise of transmit-ready |

## Verification
The bench builds the block with a 6-bit divider field and a reset divider of 3, so a byte takes 72 clocks. Many transfers therefore fit in a short run. One transfer reprograms the divider to 5 to show that the phase length follows the register and not the parameter. The slave model acknowledges its address only while a ready input is high. This makes reachable the missing-acknowledge path, the three-flag pile-up, the automatic STOP and a polled retry that then succeeds.

// File: rtl/i2c_txm_pkg.sv
package i2c_txm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_BIT_LO, ST_BIT_HI, ST_ACK_LO,
    ST_ACK_HI, ST_HOLD, ST_STOP_LO, ST_STOP_HI
  } bus_state_e;

  localparam logic [2:0] RA_CTRL    = 3'd0;
  localparam logic [2:0] RA_SADDR   = 3'd1;
  localparam logic [2:0] RA_THR     = 3'd2;
  localparam logic [2:0] RA_STAT    = 3'd3;
  localparam logic [2:0] RA_IEN_SET = 3'd4;
  localparam logic [2:0] RA_IEN_CLR = 3'd5;
  localparam logic [2:0] RA_IEN     = 3'd6;
  localparam logic [2:0] RA_DIV     = 3'd7;

  localparam int FLAG_W      = 3;
  localparam int FLAG_TXRDY  = 0;
  localparam int FLAG_TXCOMP = 1;
  localparam int FLAG_NACK   = 2;
endpackage

// File: rtl/i2c_txm_tick.sv
module i2c_txm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= div;
    else           cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/i2c_txm_engine.sv
module i2c_txm_engine
  import i2c_txm_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SADR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [BYTE_W-1:0] hold_byte,
  input  logic [SADR_W-1:0] slave_addr,
  input  logic              stop_req,
  input  logic              sda_in,
  output logic              take_byte,
  output logic              nack_evt,
  output logic              comp_evt,
  output logic              stop_done,
  output logic              scl_low,
  output logic              sda_low,
  output bus_state_e        state_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  bus_state_e        state_q;
  logic [BYTE_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_q;
  logic              ack_tick;

  assign ack_tick  = (state_q == ST_ACK_HI) && tick;
  assign nack_evt  = ack_tick && sda_in;
  assign take_byte = hold_full && tick &&
                     ((state_q == ST_ACK_HI && !sda_in) || state_q == ST_HOLD);
  assign comp_evt  = ack_tick && !sda_in && !hold_full && !stop_req;
  assign stop_done = (state_q == ST_STOP_HI) && tick;
  assign state_o   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shift_q <= '0;
      bit_q   <= '0;
    end else if (tick) begin
      unique case (state_q)
        ST_IDLE: if (hold_full) begin
          state_q <= ST_START;
          shift_q <= {slave_addr, 1'b0};
          bit_q   <= LAST_BIT;
        end
        ST_START:  state_q <= ST_BIT_LO;
        ST_BIT_LO: state_q <= ST_BIT_HI;
        ST_BIT_HI: if (bit_q == '0) state_q <= ST_ACK_LO;
                   else begin
                     bit_q   <= bit_q - 1'b1;
                     shift_q <= shift_q << 1;
                     state_q <= ST_BIT_LO;
                   end
        ST_ACK_LO: state_q <= ST_ACK_HI;
        ST_ACK_HI, ST_HOLD: begin
          if (state_q == ST_ACK_HI && sda_in) state_q <= ST_STOP_LO;
          else if (hold_full) begin
            shift_q <= hold_byte;
            bit_q   <= LAST_BIT;
            state_q <= ST_BIT_LO;
          end
          else if (stop_req) state_q <= ST_STOP_LO;
          else               state_q <= ST_HOLD;
        end
        ST_STOP_LO: state_q <= ST_STOP_HI;
        ST_STOP_HI: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_low = state_q inside {ST_BIT_LO, ST_ACK_LO, ST_HOLD, ST_STOP_LO};
    sda_low = (state_q inside {ST_START, ST_HOLD, ST_STOP_LO, ST_STOP_HI}) ||
              ((state_q inside {ST_BIT_LO, ST_BIT_HI}) && !shift_q[BYTE_W-1]);
  end
endmodule

// File: rtl/i2c_txm_flags.sv
module i2c_txm_flags
  import i2c_txm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic              stat_rd,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic [FLAG_W-1:0] ien_bits,
  input  logic              hold_full,
  input  logic              nack_evt,
  input  logic              comp_evt,
  input  logic              stop_done,
  output logic [FLAG_W-1:0] status,
  output logic [FLAG_W-1:0] mask,
  output logic              irq,
  output logic              dma_req
);
  logic txcomp_q, nack_q, txrdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txcomp_q <= 1'b1;
      nack_q   <= 1'b0;
      txrdy_q  <= 1'b1;
      mask     <= '0;
    end else begin
      if (thr_wr)                                txcomp_q <= 1'b0;
      else if (nack_evt || comp_evt || stop_done) txcomp_q <= 1'b1;
      if (nack_evt)     nack_q <= 1'b1;
      else if (stat_rd) nack_q <= 1'b0;
      txrdy_q <= !hold_full;
      if (ien_set)      mask <= mask | ien_bits;
      else if (ien_clr) mask <= mask & ~ien_bits;
    end
  end

  always_comb begin
    status              = '0;
    status[FLAG_TXRDY]  = !hold_full;
    status[FLAG_TXCOMP] = txcomp_q;
    status[FLAG_NACK]   = nack_q;
    irq                 = |(status & mask);
    dma_req             = !hold_full && !txrdy_q;
  end
endmodule

// File: rtl/i2c_txm_top.sv
module i2c_txm_top
  import i2c_txm_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_low,
  output logic       sda_low,
  input  logic       sda_in,
  output logic       irq,
  output logic       dma_req
);
  localparam int BYTE_W = 8;
  localparam int SADR_W = 7;
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic [DIV_W-1:0]  div_q;
  logic [SADR_W-1:0] saddr_q;
  logic [BYTE_W-1:0] hold_q;
  logic              hold_full_q, stop_req_q;
  logic              tick, take_byte, nack_evt, comp_evt, stop_done;
  logic              thr_wr, stop_wr, bus_free;
  logic [FLAG_W-1:0] flag_stat, flag_mask;
  bus_state_e        eng_state;

  assign thr_wr   = reg_wr && reg_addr == RA_THR;
  assign stop_wr  = reg_wr && reg_addr == RA_CTRL && reg_wdata[0];
  assign bus_free = eng_state == ST_IDLE && !hold_full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= DIV_INIT;
      saddr_q     <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      stop_req_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_DIV)   div_q   <= reg_wdata[DIV_W-1:0];
      if (reg_wr && reg_addr == RA_SADDR) saddr_q <= reg_wdata[SADR_W-1:0];
      if (thr_wr) begin
        hold_q      <= reg_wdata;
        hold_full_q <= 1'b1;
      end else if (take_byte || nack_evt) hold_full_q <= 1'b0;
      if (stop_done)                 stop_req_q <= 1'b0;
      else if (stop_wr && !bus_free) stop_req_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_STAT: reg_rdata = {{(8-FLAG_W){1'b0}}, flag_stat};
      RA_IEN:  reg_rdata = {{(8-FLAG_W){1'b0}}, flag_mask};
      default: reg_rdata = '0;
    endcase
  end

  i2c_txm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
  );

  i2c_txm_engine #(.BYTE_W(BYTE_W), .SADR_W(SADR_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full_q),
    .hold_byte(hold_q), .slave_addr(saddr_q), .stop_req(stop_req_q),
    .sda_in(sda_in), .take_byte(take_byte), .nack_evt(nack_evt),
    .comp_evt(comp_evt), .stop_done(stop_done), .scl_low(scl_low),
    .sda_low(sda_low), .state_o(eng_state)
  );

  i2c_txm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr),
    .stat_rd(reg_rd && reg_addr == RA_STAT),
    .ien_set(reg_wr && reg_addr == RA_IEN_SET),
    .ien_clr(reg_wr && reg_addr == RA_IEN_CLR),
    .ien_bits(reg_wdata[FLAG_W-1:0]), .hold_full(hold_full_q),
    .nack_evt(nack_evt), .comp_evt(comp_evt), .stop_done(stop_done),
    .status(flag_stat), .mask(flag_mask), .irq(irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/i2c_txm_chk.sv
module i2c_txm_chk
  import i2c_txm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic [FLAG_W-1:0] ien_bits,
  input logic              dma_req,
  input logic              irq,
  input logic [FLAG_W-1:0] status,
  input logic              nack_evt,
  input bus_state_e        eng_state
);
  AST_TRIPLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt && !(reg_wr && reg_addr == RA_THR) |=> status == 3'b111); // R8

  AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> eng_state == ST_STOP_LO); // R7

  AST_TXCOMP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == RA_THR |=> !status[FLAG_TXCOMP]); // R5

  AST_NACK_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == RA_STAT && !nack_evt |=> !status[FLAG_NACK]); // R9

  AST_DMA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R3

  AST_IRQ_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_rd && reg_addr == RA_IEN_SET && |(ien_bits & status) |=> irq); // R10
endmodule

bind i2c_txm_top i2c_txm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .ien_bits(reg_wdata[2:0]), .dma_req(dma_req),
  .irq(irq), .status(flag_stat), .nack_evt(nack_evt), .eng_state(eng_state)
);

// File: tb/sim_i2c_txm_top.sv
module sim_i2c_txm_top;
  import i2c_txm_pkg::*;

  localparam int DIV_W = 6;
  localparam int DIV_RST = 3;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, reg_wr, reg_rd, irq, dma_req, scl_low, sda_low, sda_in;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic slv_low, slave_ready, scl_line;

  assign scl_line = !scl_low;
  assign sda_in   = !(sda_low || slv_low);

  i2c_txm_top #(.DIV_W(DIV_W), .DIV_RESET(DIV_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_in),
    .irq(irq), .dma_req(dma_req)
  );

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  int start_cnt, stop_cnt, addr_seen, bitcnt, hi_len, last_hi, dma_cnt;
  logic prev_scl, prev_sda, in_addr, ack_next, dma_prev;
  logic [7:0] sh;

  always @(negedge clk) begin
    if (!rst_n) begin
      start_cnt = 0; stop_cnt = 0; addr_seen = 0; bitcnt = 0; hi_len = 0;
      last_hi = 0; prev_scl = 1; prev_sda = 1; in_addr = 0; ack_next = 0;
      slv_low = 0; sh = 0; dma_cnt = 0; dma_prev = 0;
    end else begin
      if (dma_req) dma_cnt++;
      if (dma_req && dma_prev) check(0, "R3 dma width", 2, 1);
      dma_prev = dma_req;
      if (prev_scl && scl_line && prev_sda && !sda_in) begin
        start_cnt++; bitcnt = 0; in_addr = 1;
      end else if (prev_scl && scl_line && !prev_sda && sda_in) begin
        stop_cnt++; bitcnt = 0;
      end
      if (!prev_scl && scl_line) begin
        hi_len = 1;
        if (bitcnt < 8) begin
          sh = {sh[6:0], sda_in};
          bitcnt++;
          if (bitcnt == 8) begin
            if (in_addr) begin
              addr_seen++;
              check(sh == {SLV, 1'b0}, "R2 address byte", sh, {SLV, 1'b0});
              ack_next = slave_ready;
            end else begin
              if (exp_q.size() == 0) check(0, "R2 unexpected byte", sh, 0);
              else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(sh == e, "R2 data byte", sh, e);
              end
              ack_next = 1;
            end
          end
        end else if (bitcnt == 8) bitcnt = 9;
      end else if (scl_line) hi_len++;
      if (prev_scl && !scl_line) begin
        if (bitcnt >= 1 && bitcnt <= 8) last_hi = hi_len;
        if (bitcnt == 8) slv_low = ack_next;
        else if (bitcnt == 9) begin slv_low = 0; bitcnt = 0; in_addr = 0; end
      end
      prev_scl = scl_line;
      prev_sda = sda_in;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_addr = RA_STAT;
  endtask

  task automatic stat_read();
    @(negedge clk); reg_addr = RA_STAT; reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_flag(input int idx, input logic val, input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (reg_rdata[idx] == val) return;
    end
    check(0, req, !val, val);
  endtask

  task automatic wait_stops(input int n, input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (stop_cnt >= n) return;
    end
    check(0, req, stop_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R2 watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s0, st0, d0;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = RA_STAT; reg_wdata = 0;
    slave_ready = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reg_rdata[2:0] == 3'b011, "R1 status", reg_rdata[2:0], 3'b011);
    check(!irq && !scl_low && !sda_low, "R1 lines", {irq, scl_low, sda_low}, 0);
    reg_addr = RA_IEN;
    @(negedge clk);
    check(reg_rdata[2:0] == 0, "R1 mask", reg_rdata[2:0], 0);
    reg_addr = RA_STAT;

    // two bytes, stop command, divider 5
    reg_write(RA_DIV, 8'd5);
    reg_write(RA_SADDR, {1'b0, SLV});
    s0 = stop_cnt; d0 = dma_cnt;
    exp_q.push_back(8'hA5);
    reg_write(RA_THR, 8'hA5);
    check(reg_rdata[FLAG_TXRDY] == 0, "R3 txrdy low", reg_rdata[FLAG_TXRDY], 0);
    wait_flag(FLAG_TXRDY, 1, "R3 txrdy rise");
    exp_q.push_back(8'h3C);
    reg_write(RA_THR, 8'h3C);
    wait_flag(FLAG_TXRDY, 1, "R3 txrdy rise 2");
    reg_write(RA_CTRL, 8'h01);
    wait_stops(s0 + 1, "R6 stop after command");
    @(negedge clk);
    check(reg_rdata[FLAG_TXCOMP] == 1, "R6 txcomp at end", reg_rdata[FLAG_TXCOMP], 1);
    check(dma_cnt - d0 == 2, "R3 dma pulses", dma_cnt - d0, 2);
    check(last_hi == 6, "R11 scl high length", last_hi, 6);
    check(exp_q.size() == 0, "R2 bytes delivered", exp_q.size(), 0);
    check(!scl_low && !sda_low, "R6 bus released", {scl_low, sda_low}, 0);
    reg_write(RA_DIV, 8'(DIV_RST));

    // stop on a free bus is ignored; hold after the last byte
    s0 = stop_cnt; st0 = start_cnt;
    reg_write(RA_CTRL, 8'h01);
    repeat (30) @(negedge clk);
    check(stop_cnt == s0 && start_cnt == st0, "R6 idle stop ignored", stop_cnt - s0, 0);
    exp_q.push_back(8'h11);
    reg_write(RA_THR, 8'h11);
    wait_flag(FLAG_TXCOMP, 1, "R4 txcomp on hold");
    repeat (30) @(negedge clk);
    check(stop_cnt == s0, "R4 no stop while holding", stop_cnt - s0, 0);
    check(scl_low == 1, "R4 scl held low", scl_low, 1);
    exp_q.push_back(8'h22);
    reg_write(RA_THR, 8'h22);
    check(reg_rdata[FLAG_TXCOMP] == 0, "R5 txcomp cleared", reg_rdata[FLAG_TXCOMP], 0);
    wait_flag(FLAG_TXRDY, 1, "R4 resume");
    reg_write(RA_CTRL, 8'h01);
    wait_stops(s0 + 1, "R6 stop after hold");
    check(exp_q.size() == 0, "R4 bytes delivered", exp_q.size(), 0);

    // missing acknowledge
    slave_ready = 0;
    s0 = stop_cnt;
    reg_write(RA_THR, 8'h5A);
    wait_flag(FLAG_NACK, 1, "R8 nack seen");
    check(reg_rdata[2:0] == 3'b111, "R8 three flags", reg_rdata[2:0], 3'b111);
    wait_stops(s0 + 1, "R7 automatic stop");
    st0 = start_cnt;
    repeat (40) @(negedge clk);
    check(start_cnt == st0, "R7 no restart", start_cnt - st0, 0);
    check(reg_rdata[FLAG_TXRDY] == 1, "R7 held byte dropped", reg_rdata[FLAG_TXRDY], 1);
    check(reg_rdata[FLAG_NACK] == 1, "R9 peek keeps nack", reg_rdata[FLAG_NACK], 1);
    check(irq == 0, "R10 masked", irq, 0);
    reg_write(RA_IEN_SET, 8'h04);
    check(irq == 1, "R10 irq at once", irq, 1);
    reg_addr = RA_IEN;
    @(negedge clk);
    check(reg_rdata[2:0] == 3'b100, "R10 mask read", reg_rdata[2:0], 3'b100);
    reg_addr = RA_STAT;
    reg_write(RA_IEN_CLR, 8'h04);
    check(irq == 0, "R10 irq masked again", irq, 0);
    stat_read();
    check(reg_rdata[2:0] == 3'b011, "R9 read clears nack", reg_rdata[2:0], 3'b011);

    // polled retry succeeds
    slave_ready = 1;
    s0 = stop_cnt;
    exp_q.push_back(8'h77);
    reg_write(RA_THR, 8'h77);
    reg_write(RA_CTRL, 8'h01);
    wait_stops(s0 + 1, "R6 retry stop");
    @(negedge clk);
    check(exp_q.size() == 0, "R2 retry byte", exp_q.size(), 0);
    check(reg_rdata[2:0] == 3'b011, "R2 retry status", reg_rdata[2:0], 3'b011);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule